// File: doc/BRIEF.md
# Three-Wire Control Register Slave

This block lets a host processor read and write a small set of control registers over three wires: an active-low select, a serial clock and one shared data line. Each access is a 16-slot frame sent most significant bit first. The frame carries a direction bit, a 6-bit register address, one turnaround slot and 8 data bits. Writes change nothing until the last slot of the frame. Reads return the register contents on the falling serial clock edges that follow the turnaround slot. The decoded register fields leave the block as parallel outputs for the receiver circuits around it.

The serial inputs are oversampled by the block's own clock. Each input passes through a synchroniser, and serial clock edges are found by comparing the synchronised level with its value one cycle earlier. A frame state machine consumes these edges. Its states are:

- IDLE: deselected.
- CMD: collecting the direction bit and the address.
- WGAP: write turnaround slot.
- WDATA: collecting write data.
- RTURN: read turnaround slot.
- RLEAD: waiting for the first output edge.
- RSHIFT: shifting read data out.
- RDONE: read finished; all further clocks ignored.

Its transitions are:

- IDLE→CMD when select falls.
- CMD→WGAP or CMD→RTURN on the 7th rising edge, chosen by the direction bit.
- WGAP→WDATA on the next rising edge.
- WDATA→CMD on the 16th rising edge, where the write commits.
- RTURN→RLEAD on the 8th rising edge.
- RLEAD→RSHIFT on the 8th falling edge.
- RSHIFT→RDONE after the 8th data bit.
- Any state→IDLE when select rises.

A write of the key value to the reset address restores every register.

Top module: `reg3w_slave`

## Requirements
- R1: After the hardware reset input `rst_n` is released, control register 1 reads 0x85 and control register 2 reads 0x04. The outputs are taken from these bit positions. Register 1: `ldo_unclamp`=bit 7, `ldo_enable`=bit 6, `filt_bw`=bits 5:4, `lo_sel`=bits 3:2, `pwr_mode`=bits 1:0. Register 2: `agc_rate`=bits 5:4, `agc_coarse`=bit 2, `wide_dev`=bit 1, `cal_go`=bit 0.
- R2: A write frame is 16 slots, each sampled on a rising `ser_clk` edge while `ser_csn` is low. The slots are, in order: a 0 (write), address bits 5 to 0, one turnaround slot whose value is ignored, then data bits 7 to 0. Address 0x01 is register 1 and address 0x02 is register 2. The addressed register takes the data only at the 16th rising edge.
- R3: If `ser_csn` rises before the 16th rising edge of a write, no register changes.
- R4: While `ser_csn` stays low, further 16-slot write frames may follow at once, and each one commits.
- R5: A read frame starts with a 1 followed by address bits 5 to 0, sampled on the first 7 rising edges. The 8th slot is a turnaround. Data bits 7 to 0 are then placed on `ser_dout` at falling edges 8 to 15, so the host can sample them at rising edges 9 to 16.
- R6: `ser_doe` is high only from the 8th to the 16th falling edge of a read. It falls once `ser_csn` goes high.
- R7: After one read, further serial clocks in the same selection neither drive the line nor write any register, until `ser_csn` rises.
- R8: Writing 0xAA to address 0x03 sets register 1 to 0x84 (its reset value with mode bits 00) and register 2 to 0x04. Any other value written to 0x03 has no effect.
- R9: Reads of any address other than 0x01 and 0x02 return 0x00, including 0x03. Writes to addresses other than 0x01, 0x02 and 0x03 have no effect.
- R10: While `rst_n` is low, the block holds both registers at 0x85 and 0x04 and keeps `ser_doe` low, even in the middle of activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ser_csn | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock from the host, idles low |
| ser_din | input | 1 | Data line value seen at the pad input |
| ser_dout | output | 1 | Read data to the pad driver |
| ser_doe | output | 1 | Pad driver enable for read data |
| ldo_unclamp | output | 1 | Register 1 bit 7 |
| ldo_enable | output | 1 | Register 1 bit 6 |
| filt_bw | output | 2 | Register 1 bits 5:4, filter bandwidth select |
| lo_sel | output | 2 | Register 1 bits 3:2, local frequency select |
| pwr_mode | output | 2 | Register 1 bits 1:0, operating mode |
| agc_rate | output | 2 | Register 2 bits 5:4, gain loop response rate |
| agc_coarse | output | 1 | Register 2 bit 2, gain step size |
| wide_dev | output | 1 | Register 2 bit 1, deviation range |
| cal_go | output | 1 | Register 2 bit 0, calibration trigger |

## Verification
The hardest situation to reach is a selection that carries a finished read followed by more serial clocks. From the pins, those clocks look like a perfectly valid write frame. The stimulus completes a read of register 1 and keeps select low. It then clocks in a full write of 0xFF to register 2 and checks on every cycle that the pad enable stays low. A later read shows register 2 unchanged. Aborted writes cut at slot 10 and at slot 15, chained writes with a non-zero turnaround slot, and a hardware reset between frames cover the other edges of the frame logic.

// File: rtl/reg3w_pkg.sv
`timescale 1ns/1ps
package reg3w_pkg;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = 1 + ADDR_W + 1 + DATA_W;

    localparam logic [ADDR_W-1:0] ADR_CTRL1 = 6'h01;
    localparam logic [ADDR_W-1:0] ADR_CTRL2 = 6'h02;
    localparam logic [ADDR_W-1:0] ADR_SRST  = 6'h03;

    localparam logic [DATA_W-1:0] RST_CTRL1 = 8'h85;
    localparam logic [DATA_W-1:0] RST_CTRL2 = 8'h04;
    localparam logic [DATA_W-1:0] SRST_KEY  = 8'hAA;
    localparam logic [DATA_W-1:0] MODE_MASK = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WGAP,
        ST_WDATA,
        ST_RTURN,
        ST_RLEAD,
        ST_RSHIFT,
        ST_RDONE
    } ser_state_e;
endpackage

// File: rtl/reg3w_sync.sv
`timescale 1ns/1ps
module reg3w_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= RST_VAL;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
                end else begin
                    stage_q[0] <= d;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign q = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/reg3w_frame.sv
`timescale 1ns/1ps
module reg3w_frame
    import reg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              ser_dout,
    output logic              ser_doe
);
    localparam int CNT_W    = $clog2(FRAME_BITS);
    localparam int CMD_END  = ADDR_W;
    localparam int DATA_END = FRAME_BITS - 1;

    ser_state_e         state, nxt;
    logic               sclk_q;
    logic               rise, fall;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  cmd_sr;
    logic [DATA_W-2:0]  dat_sr;
    logic [DATA_W-1:0]  tx_sr;

    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (csn_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_CMD;
                ST_CMD:    if (rise && cnt == CNT_W'(CMD_END))
                               nxt = cmd_sr[ADDR_W-1] ? ST_RTURN : ST_WGAP;
                ST_WGAP:   if (rise) nxt = ST_WDATA;
                ST_WDATA:  if (rise && cnt == CNT_W'(DATA_END)) nxt = ST_CMD;
                ST_RTURN:  if (rise) nxt = ST_RLEAD;
                ST_RLEAD:  if (fall) nxt = ST_RSHIFT;
                ST_RSHIFT: if (fall && cnt == '0) nxt = ST_RDONE;
                ST_RDONE:  nxt = ST_RDONE;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            cnt      <= '0;
            cmd_sr   <= '0;
            dat_sr   <= '0;
            tx_sr    <= '0;
            acc_addr <= '0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
            ser_dout <= 1'b0;
            ser_doe  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            wr_stb <= 1'b0;
            if (csn_s) begin
                cnt      <= '0;
                ser_doe  <= 1'b0;
                ser_dout <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: cnt <= '0;
                    ST_CMD: begin
                        if (rise) begin
                            cmd_sr <= {cmd_sr[ADDR_W-2:0], din_s};
                            cnt    <= cnt + 1'b1;
                            if (cnt == CNT_W'(CMD_END))
                                acc_addr <= {cmd_sr[ADDR_W-2:0], din_s};
                        end
                    end
                    ST_WGAP: begin
                        if (rise) cnt <= cnt + 1'b1;
                    end
                    ST_WDATA: begin
                        if (rise) begin
                            dat_sr <= {dat_sr[DATA_W-3:0], din_s};
                            if (cnt == CNT_W'(DATA_END)) begin
                                wr_stb  <= 1'b1;
                                wr_data <= {dat_sr, din_s};
                                cnt     <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RLEAD: begin
                        if (fall) begin
                            ser_dout <= rd_data[DATA_W-1];
                            tx_sr    <= {rd_data[DATA_W-2:0], 1'b0};
                            ser_doe  <= 1'b1;
                            cnt      <= CNT_W'(DATA_W - 1);
                        end
                    end
                    ST_RSHIFT: begin
                        if (fall) begin
                            if (cnt == '0) begin
                                ser_doe  <= 1'b0;
                                ser_dout <= 1'b0;
                            end else begin
                                ser_dout <= tx_sr[DATA_W-1];
                                tx_sr    <= {tx_sr[DATA_W-2:0], 1'b0};
                                cnt      <= cnt - 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/reg3w_regs.sv
`timescale 1ns/1ps
module reg3w_regs
    import reg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl1,
    output logic [DATA_W-1:0] ctrl2
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl1 <= RST_CTRL1;
            ctrl2 <= RST_CTRL2;
        end else if (wr_stb) begin
            if (acc_addr == ADR_CTRL1) begin
                ctrl1 <= wr_data;
            end else if (acc_addr == ADR_CTRL2) begin
                ctrl2 <= wr_data;
            end else if (acc_addr == ADR_SRST && wr_data == SRST_KEY) begin
                ctrl1 <= RST_CTRL1 & ~MODE_MASK;
                ctrl2 <= RST_CTRL2;
            end
        end
    end

    always_comb begin
        if (acc_addr == ADR_CTRL1)      rd_data = ctrl1;
        else if (acc_addr == ADR_CTRL2) rd_data = ctrl2;
        else                            rd_data = '0;
    end
endmodule

// File: rtl/reg3w_slave.sv
`timescale 1ns/1ps
module reg3w_slave
    import reg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_csn,
    input  logic       ser_clk,
    input  logic       ser_din,
    output logic       ser_dout,
    output logic       ser_doe,
    output logic       ldo_unclamp,
    output logic       ldo_enable,
    output logic [1:0] filt_bw,
    output logic [1:0] lo_sel,
    output logic [1:0] pwr_mode,
    output logic [1:0] agc_rate,
    output logic       agc_coarse,
    output logic       wide_dev,
    output logic       cal_go
);
    logic              csn_s, sclk_s, din_s;
    logic [ADDR_W-1:0] acc_addr;
    logic              wr_stb;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] ctrl1, ctrl2;

    reg3w_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ser_csn, ser_clk, ser_din}),
        .q    ({csn_s, sclk_s, din_s})
    );

    reg3w_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .csn_s   (csn_s),
        .sclk_s  (sclk_s),
        .din_s   (din_s),
        .rd_data (rd_data),
        .acc_addr(acc_addr),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .ser_dout(ser_dout),
        .ser_doe (ser_doe)
    );

    reg3w_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .acc_addr(acc_addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ctrl1   (ctrl1),
        .ctrl2   (ctrl2)
    );

    assign ldo_unclamp = ctrl1[7];
    assign ldo_enable  = ctrl1[6];
    assign filt_bw     = ctrl1[5:4];
    assign lo_sel      = ctrl1[3:2];
    assign pwr_mode    = ctrl1[1:0];
    assign agc_rate    = ctrl2[5:4];
    assign agc_coarse  = ctrl2[2];
    assign wide_dev    = ctrl2[1];
    assign cal_go      = ctrl2[0];
endmodule

// File: rtl/reg3w_chk.sv
`timescale 1ns/1ps
module reg3w_chk
    import reg3w_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              csn_s,
    input logic              sclk_s,
    input logic              ser_doe,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] ctrl1,
    input logic [DATA_W-1:0] ctrl2
);
    logic       sclk_prev;
    logic [3:0] oe_falls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            oe_falls  <= '0;
        end else begin
            sclk_prev <= sclk_s;
            if (!ser_doe)                   oe_falls <= '0;
            else if (!sclk_s && sclk_prev)  oe_falls <= oe_falls + 1'b1;
        end
    end

    AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !ser_doe); // R6
    AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        oe_falls <= 4'd8); // R6
    AST_COMMIT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(csn_s)); // R3
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(ctrl1) && $stable(ctrl2))); // R2
    AST_CTRL1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_addr == ADR_CTRL1) |=> ctrl1 == $past(wr_data)); // R2
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_addr == ADR_SRST && wr_data == SRST_KEY)
            |=> (ctrl1 == 8'h84 && ctrl2 == RST_CTRL2)); // R8
    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_addr != ADR_CTRL1 && acc_addr != ADR_CTRL2
            && !(acc_addr == ADR_SRST && wr_data == SRST_KEY))
            |=> ($stable(ctrl1) && $stable(ctrl2))); // R9
endmodule

bind reg3w_slave reg3w_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .csn_s   (csn_s),
    .sclk_s  (sclk_s),
    .ser_doe (ser_doe),
    .wr_stb  (wr_stb),
    .acc_addr(acc_addr),
    .wr_data (wr_data),
    .ctrl1   (ctrl1),
    .ctrl2   (ctrl2)
);

// File: tb/reg3w_slave_tb.sv
`timescale 1ns/1ps
module reg3w_slave_tb;
    import reg3w_pkg::*;

    localparam int HALF   = 8;
    localparam int SETTLE = 6;
    localparam int WDOG   = 150000;

    logic clk = 1'b0, rst_n = 1'b0, csn = 1'b1, sclk = 1'b0, din = 1'b0;
    logic ser_dout, ser_doe, ldo_unclamp, ldo_enable, agc_coarse, wide_dev, cal_go;
    logic [1:0] filt_bw, lo_sel, pwr_mode, agc_rate;

    reg3w_slave u_dut (
        .clk(clk), .rst_n(rst_n), .ser_csn(csn), .ser_clk(sclk), .ser_din(din),
        .ser_dout(ser_dout), .ser_doe(ser_doe),
        .ldo_unclamp(ldo_unclamp), .ldo_enable(ldo_enable), .filt_bw(filt_bw),
        .lo_sel(lo_sel), .pwr_mode(pwr_mode), .agc_rate(agc_rate),
        .agc_coarse(agc_coarse), .wide_dev(wide_dev), .cal_go(cal_go)
    );

    always #2.5 clk = ~clk;

    int n_vec = 0, n_bad = 0, settle = SETTLE, cyc = 0;
    logic [7:0] e1 = RST_CTRL1, e2 = RST_CTRL2;
    logic e_oe = 1'b0;

    function automatic logic [7:0] act1();
        return {ldo_unclamp, ldo_enable, filt_bw, lo_sel, pwr_mode};
    endfunction
    function automatic logic [7:0] act2();
        return {2'b00, agc_rate, 1'b0, agc_coarse, wide_dev, cal_go};
    endfunction

    task automatic chk(string tag, logic [7:0] a, logic [7:0] e);
        n_vec++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, a, e);
        end
    endtask

    // one clock of the reference comparison
    task automatic tick();
        @(negedge clk);
        if (settle > 0) settle--;
        else begin
            chk("R2 ctrl1 fields", act1(), e1);
            chk("R2 ctrl2 fields", act2(), e2 & 8'h37);
            chk("R6 pad enable", {7'b0, ser_doe}, {7'b0, e_oe});
        end
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic model_write(logic [5:0] a, logic [7:0] d);
        if (a == ADR_CTRL1) e1 = d;
        else if (a == ADR_CTRL2) e2 = d;
        else if (a == ADR_SRST && d == SRST_KEY) begin
            e1 = 8'h84;
            e2 = RST_CTRL2;
        end
    endtask

    task automatic sel(logic v);
        csn = v; settle = SETTLE;
        wait_n(HALF);
    endtask

    // f[15]=dir, f[14:9]=addr, f[8]=turnaround, f[7:0]=data
    task automatic send_bits(logic [15:0] f, int n, bit live);
        for (int i = 0; i < n; i++) begin
            din = f[15-i]; settle = SETTLE;
            wait_n(HALF);
            sclk = 1'b1; settle = SETTLE;
            if (i == 15 && live && !f[15]) model_write(f[14:9], f[7:0]);
            wait_n(HALF);
            sclk = 1'b0; settle = SETTLE;
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        sel(1'b0);
        send_bits({1'b0, a, 1'b0, d}, 16, 1'b1);
        sel(1'b1);
    endtask

    task automatic rd(logic [5:0] a, logic [7:0] exp, string tag, bit trailing);
        sel(1'b0);
        send_bits({1'b1, a, 9'b0}, 7, 1'b0);
        din = 1'b0; settle = SETTLE;
        wait_n(HALF);
        sclk = 1'b1; settle = SETTLE;
        wait_n(HALF);
        sclk = 1'b0; e_oe = 1'b1; settle = SETTLE;
        for (int k = 0; k < 8; k++) begin
            wait_n(HALF);
            chk({tag, " R5 read bit"}, {7'b0, ser_dout}, {7'b0, exp[7-k]});
            chk({tag, " R6 enable in data slot"}, {7'b0, ser_doe}, 8'h01);
            sclk = 1'b1; settle = SETTLE;
            wait_n(HALF);
            sclk = 1'b0; settle = SETTLE;
            if (k == 7) e_oe = 1'b0;
        end
        wait_n(HALF);
        if (trailing) send_bits({1'b0, ADR_CTRL2, 1'b0, 8'hFF}, 16, 1'b0); // R7
        sel(1'b1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_bad++;
            $display("FAIL R10 watchdog actual=%0d expected<%0d", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1; settle = SETTLE;
        wait_n(10);
        chk("R1 reset ctrl1", act1(), RST_CTRL1);
        chk("R1 reset ctrl2", act2(), RST_CTRL2);
        chk("R10 reset enable", {7'b0, ser_doe}, 8'h00);

        rd(ADR_CTRL1, 8'h85, "R1 ctrl1", 1'b0);
        rd(ADR_CTRL2, 8'h04, "R1 ctrl2", 1'b0);

        wr(ADR_CTRL1, 8'h3A);
        wr(ADR_CTRL2, 8'hC6);
        rd(ADR_CTRL1, 8'h3A, "R2 write", 1'b0);
        rd(ADR_CTRL2, 8'hC6, "R2 write", 1'b0);

        // R3 aborted writes
        sel(1'b0); send_bits({1'b0, ADR_CTRL1, 1'b0, 8'hFF}, 10, 1'b1); sel(1'b1);
        sel(1'b0); send_bits({1'b0, ADR_CTRL1, 1'b0, 8'hFF}, 15, 1'b1); sel(1'b1);
        rd(ADR_CTRL1, 8'h3A, "R3 abort", 1'b0);

        // R4 chained frames, second with turnaround slot set
        sel(1'b0);
        send_bits({1'b0, ADR_CTRL1, 1'b0, 8'h5B}, 16, 1'b1);
        send_bits({1'b0, ADR_CTRL2, 1'b1, 8'h13}, 16, 1'b1);
        sel(1'b1);
        rd(ADR_CTRL1, 8'h5B, "R4 chain", 1'b0);
        rd(ADR_CTRL2, 8'h13, "R4 chain", 1'b0);

        // R7 clocks after a read are ignored
        rd(ADR_CTRL1, 8'h5B, "R7 first read", 1'b1);
        rd(ADR_CTRL2, 8'h13, "R7 untouched", 1'b0);

        // R9 undefined addresses
        wr(6'h05, 8'h77);
        wr(6'h3F, 8'h11);
        wr(6'h00, 8'h22);
        rd(6'h05, 8'h00, "R9 addr05", 1'b0);
        rd(6'h00, 8'h00, "R9 addr00", 1'b0);
        rd(6'h3F, 8'h00, "R9 addr3f", 1'b0);
        rd(ADR_SRST, 8'h00, "R9 addr03", 1'b0);
        rd(ADR_CTRL1, 8'h5B, "R9 unchanged", 1'b0);

        // R8 software reset
        wr(ADR_SRST, 8'h55);
        rd(ADR_CTRL1, 8'h5B, "R8 wrong key", 1'b0);
        wr(ADR_SRST, SRST_KEY);
        chk("R8 soft reset ctrl1", act1(), 8'h84);
        chk("R8 soft reset ctrl2", act2(), 8'h04);
        rd(ADR_CTRL1, 8'h84, "R8 after", 1'b0);
        rd(ADR_SRST, 8'h00, "R8 key reads zero", 1'b0);

        // R10 hardware reset
        wr(ADR_CTRL1, 8'hFF);
        wr(ADR_CTRL2, 8'h37);
        @(negedge clk);
        rst_n = 1'b0; e1 = RST_CTRL1; e2 = RST_CTRL2; e_oe = 1'b0; settle = 2;
        wait_n(4);
        chk("R10 in reset", act1(), RST_CTRL1);
        rst_n = 1'b1; settle = SETTLE;
        wait_n(10);
        chk("R10 after reset ctrl2", act2(), RST_CTRL2);
        rd(ADR_CTRL1, 8'h85, "R10 readback", 1'b0);

        wait_n(20);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule